// File: doc/BRIEF.md
# Transmit Self-Test Character Generator

This block sits between a transmit FIFO and the link encoder and sends one 10-bit character per clock. In normal operation it pops characters from a show-ahead FIFO whenever the FIFO is not empty and presents each popped character, marked valid, one clock later. When the asynchronous active-low self-test enable is recognised, the block stops reading the FIFO. It then sends a pseudo-random character stream from a 9-bit LFSR, and that stream repeats every 511 characters. Characters already queued stay in the FIFO and go out, in order, once the test ends.

The host may keep writing to the FIFO during the test, and may also clear it. The full flag passes straight through at all times, so the end of a clear can still be seen there. While the test runs, the empty flag shows a one-character loop marker in place of FIFO emptiness. A mode input sets the polarity of both flags: active high in the cascade timing model and active low in the UTOPIA-style model.

Top module: `txbist_gen`

## Requirements
- R1: The test enable goes through a two-flop synchronizer plus one state register. If `bist_en_n` is sampled at a clock edge k, `bist_active` takes its inverse after edge k+2 and not earlier.
- R2: While a test runs, each clock emits one valid character `{^s, s}`, where `s` is the 9-bit LFSR state. The state then advances as `s <= {s[7:0], s[8]^s[4]}`. The first test character comes one clock after `bist_active` rises.
- R3: `fifo_rd` is never high while `bist_active` is high.
- R4: Outside a test, `fifo_rd` is high exactly when `fifo_empty` is low. The character read appears on `tx_char` with `tx_valid` high after the next edge. When nothing is read, `tx_valid` is low. Queued characters leave in FIFO order, and none is lost across a test.
- R5: During a test, the loop indication is active for exactly one character each time the emitted state equals the seed `9'h1FF`. Consecutive indications are therefore 511 characters apart.
- R6: With `cascade_mode`=1, `empty_flag` and `full_flag` are active high. With `cascade_mode`=0, both are active low.
- R7: During a test, `empty_flag` ignores `fifo_empty`, including while the FIFO is being cleared. `full_flag` keeps following `fifo_full`.
- R8: During reset, `tx_valid` and `bist_active` are low, and the empty flag reports `fifo_empty`.
- R9: Every new test restarts the sequence at the seed, so the first test character is the seed character with the loop indication active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en_n | input | 1 | Asynchronous active-low self-test enable |
| cascade_mode | input | 1 | 1: flags active high; 0: flags active low |
| fifo_empty | input | 1 | FIFO empty status, active high |
| fifo_full | input | 1 | FIFO full status, active high |
| fifo_rdata | input | 10 | Show-ahead FIFO head character |
| fifo_rd | output | 1 | FIFO pop strobe |
| tx_char | output | 10 | Character to the encoder |
| tx_valid | output | 1 | tx_char holds a character this clock |
| empty_flag | output | 1 | Empty status, or loop marker during a test |
| full_flag | output | 1 | Full status |
| bist_active | output | 1 | Test mode recognised |

## Verification
The bench compares every clock with a reference model built from the requirements. The FIFO is a bench queue with random pushes, so the empty/non-empty patterns separate the read gating from plain pass-through. Test windows are entered at random points while the queue holds data, which shows whether any queued character is dropped or reordered across a test. A long test in the active-low mode measures the spacing of the loop marker. A FIFO clear in the middle of a test separates the empty flag, which must not move, from the full flag, which must.

// File: rtl/txbist_gen.sv
module txbist_gen #(
  parameter int LW = 9,
  parameter logic [LW-1:0] SEED = '1,
  parameter logic [LW-1:0] TAPS = 9'h110,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bist_en_n,
  input  logic          cascade_mode,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  input  logic [CW-1:0] fifo_rdata,
  output logic          fifo_rd,
  output logic [CW-1:0] tx_char,
  output logic          tx_valid,
  output logic          empty_flag,
  output logic          full_flag,
  output logic          bist_active
);

  logic          sync1, sync2;
  logic [LW-1:0] lfsr;
  logic          loop_q;
  logic          in_test;

  wire [LW-1:0] lfsr_nxt  = {lfsr[LW-2:0], ^(lfsr & TAPS)};
  wire          empty_ind = in_test ? loop_q : fifo_empty;

  assign fifo_rd    = !bist_active && !fifo_empty;
  assign empty_flag = cascade_mode ? empty_ind : !empty_ind;
  assign full_flag  = cascade_mode ? fifo_full : !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1       <= 1'b0;
      sync2       <= 1'b0;
      bist_active <= 1'b0;
    end else begin
      sync1       <= !bist_en_n;
      sync2       <= sync1;
      bist_active <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr     <= SEED;
      loop_q   <= 1'b0;
      in_test  <= 1'b0;
      tx_valid <= 1'b0;
      tx_char  <= '0;
    end else if (bist_active) begin
      tx_char  <= {^lfsr, lfsr};
      tx_valid <= 1'b1;
      loop_q   <= (lfsr == SEED);
      in_test  <= 1'b1;
      lfsr     <= lfsr_nxt;
    end else begin
      lfsr     <= SEED;
      loop_q   <= 1'b0;
      in_test  <= 1'b0;
      tx_valid <= fifo_rd;
      if (fifo_rd) tx_char <= fifo_rdata;
    end
  end

endmodule

// File: rtl/txbist_gen_chk.sv
module txbist_gen_chk #(
  parameter int LW = 9,
  localparam int CW = LW + 1,
  localparam int PERIOD = (1 << LW) - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bist_en_n,
  input logic          fifo_rd,
  input logic [CW-1:0] fifo_rdata,
  input logic [CW-1:0] tx_char,
  input logic          tx_valid,
  input logic          bist_active,
  input logic          in_test,
  input logic          loop_q
);

  logic [2:0]  age;
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= '0;
      gap  <= 16'd1;
      seen <= 1'b0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      if (!in_test) begin
        gap  <= 16'd1;
        seen <= 1'b0;
      end else if (loop_q) begin
        gap  <= 16'd1;
        seen <= 1'b1;
      end else begin
        gap <= gap + 16'd1;
      end
    end
  end

  a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4) |-> (bist_active == $past(!bist_en_n, 3)));

  a_r3_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    bist_active |-> !fifo_rd);

  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> (tx_valid && !in_test && tx_char == $past(fifo_rdata)));

  a_r2_test_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_test |-> tx_valid);

  a_r9_seed_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_test) |-> loop_q);

  a_r5_period: assert property (@(posedge clk) disable iff (!rst_n)
    (in_test && loop_q && seen) |-> (gap == 16'(PERIOD)));

endmodule

bind txbist_gen txbist_gen_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bist_en_n(bist_en_n), .fifo_rd(fifo_rd),
  .fifo_rdata(fifo_rdata), .tx_char(tx_char), .tx_valid(tx_valid),
  .bist_active(bist_active), .in_test(in_test), .loop_q(loop_q)
);

// File: tb/test_txbist_gen.sv
module test_txbist_gen;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 32;
  localparam logic [8:0] SEEDV = 9'h1FF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bist_en_n = 1'b1;
  logic       cascade_mode = 1'b1;
  logic       fifo_empty, fifo_full;
  logic [9:0] fifo_rdata;
  logic       fifo_rd, tx_valid, empty_flag, full_flag, bist_active;
  logic [9:0] tx_char;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbist_gen i_txbist_gen (
    .clk(clk), .rst_n(rst_n), .bist_en_n(bist_en_n), .cascade_mode(cascade_mode),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .tx_char(tx_char), .tx_valid(tx_valid),
    .empty_flag(empty_flag), .full_flag(full_flag), .bist_active(bist_active)
  );

  int checks = 0, fails = 0;
  logic [9:0] q [QD];
  int head = 0, cnt = 0;
  logic       m_s1 = 0, m_s2 = 0, m_act = 0, m_valid = 0, m_loop = 0, m_intest = 0;
  logic [8:0] m_lfsr = SEEDV;
  logic [9:0] m_char = '0;
  int stepno = 0, last_loop = -1, loop_gaps = 0;

  function automatic logic [8:0] nxt(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction
  function automatic logic [9:0] mapc(input logic [8:0] s);
    return {^s, s};
  endfunction
  function automatic logic pol(input logic cas, input logic v);
    return cas ? v : !v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (step %0d)", tag, act, exp, stepno);
    end
  endtask

  task automatic drive_q();
    fifo_empty = (cnt == 0);
    fifo_full  = (cnt == QD);
    fifo_rdata = q[head];
  endtask

  task automatic step(input logic en_n, input logic cas, input logic push, input logic clr);
    logic rd, dut_loop;
    @(negedge clk);
    stepno++;
    chk("R1 bist_active", bist_active, m_act);
    chk("R2/R4 tx_valid", tx_valid, m_valid);
    if (m_valid) chk("R2/R4 tx_char", tx_char, m_char);
    bist_en_n = en_n;
    cascade_mode = cas;
    if (clr) begin head = 0; cnt = 0; end
    if (push && cnt < QD) begin
      q[(head + cnt) % QD] = 10'($urandom);
      cnt++;
    end
    drive_q();
    #1;
    rd = !m_act && (cnt != 0);
    chk("R3/R4 fifo_rd", fifo_rd, rd);
    chk("R5/R6/R7 empty_flag", empty_flag, pol(cas, m_intest ? m_loop : (cnt == 0)));
    chk("R6/R7 full_flag", full_flag, pol(cas, cnt == QD));
    if (m_intest) begin
      dut_loop = cas ? empty_flag : !empty_flag;
      if (dut_loop) begin
        if (last_loop >= 0) begin
          chk("R5 loop spacing", stepno - last_loop, 511);
          loop_gaps++;
        end
        last_loop = stepno;
      end
    end else begin
      last_loop = -1;
    end
    // advance reference model to the state after the coming edge
    if (m_act) begin
      m_char = mapc(m_lfsr); m_valid = 1; m_loop = (m_lfsr == SEEDV);
      m_intest = 1; m_lfsr = nxt(m_lfsr);
    end else begin
      m_lfsr = SEEDV; m_loop = 0; m_intest = 0; m_valid = rd;
      if (rd) m_char = q[head];
    end
    m_act = m_s2; m_s2 = m_s1; m_s1 = !en_n;
    if (rd) begin head = (head + 1) % QD; cnt--; end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < QD; i++) q[i] = '0;
    drive_q();
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 tx_valid in reset", tx_valid, 0);
    chk("R8 bist_active in reset", bist_active, 0);
    chk("R8 empty_flag in reset", empty_flag, 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 300; i++)
      step(1'b1, (i / 50) % 2 == 0, ($urandom % 2) == 0, 1'b0);

    // R1/R3/R4/R9: short test with data queued, then resume
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, ($urandom % 3) == 0, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, ($urandom % 4) == 0, 1'b0);

    // R7: FIFO clear during a test, then fill to full
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, 1'b0);

    // R5: long test in active-low mode
    for (int i = 0; i < 1100; i++) step(1'b0, 1'b0, ($urandom % 2) == 0, 1'b0);
    chk("R5 loop markers seen", loop_gaps >= 2, 1);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 1'b0, 1'b0);

    // random enable windows, mixed modes
    for (int b = 0; b < 40; b++) begin
      logic en = ($urandom % 2) == 0;
      logic cs = ($urandom % 2) == 0;
      int len = 1 + int'($urandom % 25);
      for (int i = 0; i < len; i++) step(en, cs, ($urandom % 2) == 0, ($urandom % 97) == 0);
    end
    for (int i = 0; i < 80; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R4 queue drained", cnt, 0);
    finish_up();
  end
endmodule